// File: doc/BRIEF.md
# Dual PLL Clock Source Select Guard

This block sits between a software-written clock control register and two PLLs, either of which can drive the processor clock. For each PLL it holds three settings: a multiplier code, a frequency-band code and a power-off bit. It also holds one source-select bit. It runs a lock-wait counter for each PLL and drives the active source select. Software issues one operation per cycle. The operation can be a PLL configuration write, a select write, or a write-one-to-clear of the error flags.

The guard enforces the switching rules and rejects any operation that breaks one of them. The rules are:

- Only the PLL that is not feeding the clock may be reconfigured.
- No PLL may be selected before its lock time has passed.
- No PLL may be selected while it is switched off.
- The source may not change directly from one half-cycle ratio to another.

A rejected operation leaves every setting unchanged. It sets a sticky error bit that names the rule that was broken. Once both PLLs are locked, a legal select change takes effect on the next clock edge with no further wait.

Top module: `clksel_guard`

## Requirements
- R1: After reset the select is 0 (PLL0). PLL0 holds multiplier code RESET_MULT0, band 00, power-off 0, and reports locked when its lock input is high. PLL1 holds code 0 with power-off 1 and is not locked. All error flags are 0.
- R2: A configuration write (wr_op 0) to the PLL that is not selected, with band 00, 01 or 10, is accepted. It stores the multiplier code, band and power-off bit at the next edge.
- R3: A configuration write to the selected PLL is rejected and leaves every setting unchanged. It sets error bit 0 (wrong PLL). This check takes priority over the band check.
- R4: A configuration write with band code 11 is rejected and leaves every setting unchanged. It sets error bit 4 (reserved band). A stored band is never 11.
- R5: An accepted configuration write loads the lock counter with lock_cycles. The counter then falls by one per cycle. A PLL reports locked exactly when its counter is 0, it is not off, and its lock input is high. Locked therefore appears lock_cycles edges after the write edge.
- R6: A select write (wr_op 1) to the other PLL changes clk_sel at the next edge when that PLL is locked and no other rule forbids the change.
- R7: A PLL is off when its multiplier code is 0 or its power-off bit is 1. A select write that targets an off PLL is refused and sets error bit 2. This rule has the highest priority among the select rules.
- R8: A select write that targets a PLL which is on but not locked is refused and sets error bit 1.
- R9: Odd multiplier codes are half-cycle ratios (ratio = code/2). A select change while both PLLs hold odd codes is refused and sets error bit 3. This rule is checked after R7 and R8.
- R10: A select write whose value equals the current select has no effect and raises no error.
- R11: Error flags are sticky. A clear operation (wr_op 2) clears exactly the flags whose wr_clr bits are 1. wr_op 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | An operation is presented this cycle |
| wr_op | input | 2 | 0 configure, 1 select, 2 clear errors, 3 no operation |
| wr_pll | input | 1 | Target PLL of a configuration write |
| wr_mult | input | MULT_W | Multiplier code to store |
| wr_range | input | 2 | Band code: 00 mid, 01 fast, 10 slow, 11 reserved |
| wr_pwroff | input | 1 | Power-off bit to store |
| wr_sel | input | 1 | Requested source select |
| wr_clr | input | 5 | Write-one-to-clear mask for the error flags |
| lock_cycles | input | CNT_W | Lock-wait reload count |
| pll_lock_in | input | 2 | External lock qualifier for each PLL |
| clk_sel | output | 1 | Active clock source (0 = PLL0, 1 = PLL1) |
| pll_locked | output | 2 | Locked status of each PLL |
| cfg_mult | output | 2*MULT_W | Stored multiplier codes, PLL1 in the upper half |
| cfg_range | output | 4 | Stored band codes, PLL1 in the upper half |
| cfg_pwroff | output | 2 | Stored power-off bits |
| err_flags | output | 5 | Sticky errors: 0 wrong PLL, 1 unlocked, 2 off, 3 half swap, 4 reserved band |

## Verification
The bench drives a long pseudo-random operation stream and compares every output, every cycle, against a model computed from the rules. Directed steps precede the stream and cover the following corner cases:

- A write aimed at the running PLL. A design that let it through would change the live clock ratio.
- A band code of 11. A design that accepted it would store a reserved band.
- A select issued one cycle too early, and the exact cycle at which locked rises. A design off by one would switch to an unsettled PLL or refuse a valid change.
- Swaps between two odd codes, and a dropped external lock input. A design that got either wrong would switch between unsafe ratios or trust a PLL that has lost lock.
- Error-flag clearing with partial masks. A design that cleared too much would lose error history, and one that cleared too little would leave stale flags set.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   typedef enum logic [1:0] {
      OP_CFG = 2'd0,
      OP_SEL = 2'd1,
      OP_CLR = 2'd2,
      OP_NOP = 2'd3
   } op_e;

   localparam int ERR_W      = 5;
   localparam int ERR_WRONG  = 0;
   localparam int ERR_UNLOCK = 1;
   localparam int ERR_OFF    = 2;
   localparam int ERR_HALF   = 3;
   localparam int ERR_RANGE  = 4;

   localparam logic [1:0] BAND_RSVD = 2'b11;

endpackage

// File: rtl/clksel_lock_timer.sv
module clksel_lock_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             pll_off,
   input  logic             lock_in,
   output logic             locked
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("clksel_lock_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign locked = (cnt_q == '0) && !pll_off && lock_in;

   // R5
   cnt_up_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > $past(cnt_q)) |-> $past(load));

endmodule

// File: rtl/clksel_rules.sv
module clksel_rules
   import clksel_pkg::*;
(
   input  logic             valid,
   input  op_e              op,
   input  logic             tgt_pll,
   input  logic [1:0]       band,
   input  logic             req_sel,
   input  logic             cur_sel,
   input  logic [1:0]       pll_off,
   input  logic [1:0]       pll_locked,
   input  logic [1:0]       pll_half,
   output logic             cfg_ok,
   output logic             sel_ok,
   output logic [ERR_W-1:0] err_set
);

   always_comb begin
      cfg_ok  = 1'b0;
      sel_ok  = 1'b0;
      err_set = '0;
      if (valid && op == OP_CFG) begin
         if (tgt_pll == cur_sel)
            err_set[ERR_WRONG] = 1'b1;
         else if (band == BAND_RSVD)
            err_set[ERR_RANGE] = 1'b1;
         else
            cfg_ok = 1'b1;
      end else if (valid && op == OP_SEL && req_sel != cur_sel) begin
         if (pll_off[req_sel])
            err_set[ERR_OFF] = 1'b1;
         else if (!pll_locked[req_sel])
            err_set[ERR_UNLOCK] = 1'b1;
         else if (pll_half[0] && pll_half[1])
            err_set[ERR_HALF] = 1'b1;
         else
            sel_ok = 1'b1;
      end
   end

endmodule

// File: rtl/clksel_guard.sv
module clksel_guard
   import clksel_pkg::*;
#(
   parameter int MULT_W      = 5,
   parameter int CNT_W       = 8,
   parameter int RESET_MULT0 = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [1:0]            wr_op,
   input  logic                  wr_pll,
   input  logic [MULT_W-1:0]     wr_mult,
   input  logic [1:0]            wr_range,
   input  logic                  wr_pwroff,
   input  logic                  wr_sel,
   input  logic [4:0]            wr_clr,
   input  logic [CNT_W-1:0]      lock_cycles,
   input  logic [1:0]            pll_lock_in,
   output logic                  clk_sel,
   output logic [1:0]            pll_locked,
   output logic [2*MULT_W-1:0]   cfg_mult,
   output logic [3:0]            cfg_range,
   output logic [1:0]            cfg_pwroff,
   output logic [4:0]            err_flags
);

   localparam int NPLL      = 2;
   localparam int CODE_SPAN = 1 << MULT_W;

   generate
      if (MULT_W < 2) begin : g_bad_mult
         $error("clksel_guard: MULT_W must be at least 2");
      end
      if (RESET_MULT0 <= 0 || RESET_MULT0 >= CODE_SPAN) begin : g_bad_rst
         $error("clksel_guard: RESET_MULT0 must be a nonzero code");
      end
      if (ERR_W != 5) begin : g_bad_err
         $error("clksel_guard: error vector width mismatch");
      end
   endgenerate

   logic [MULT_W-1:0] mult_q  [NPLL];
   logic [1:0]        band_q  [NPLL];
   logic              pwr_q   [NPLL];
   logic              sel_q;
   logic [ERR_W-1:0]  err_q;

   logic [NPLL-1:0]   off_w;
   logic [NPLL-1:0]   half_w;
   logic [NPLL-1:0]   locked_w;
   logic [NPLL-1:0]   load_w;
   logic              cfg_ok;
   logic              sel_ok;
   logic [ERR_W-1:0]  err_set;
   logic [ERR_W-1:0]  clr_eff;
   op_e               op_w;

   assign op_w = op_e'(wr_op);

   genvar gi;
   generate
      for (gi = 0; gi < NPLL; gi++) begin : g_pll
         localparam logic [MULT_W-1:0] RST_CODE =
            (gi == 0) ? MULT_W'(RESET_MULT0) : '0;
         localparam logic RST_PWR = (gi != 0);

         assign off_w[gi]  = (mult_q[gi] == '0) || pwr_q[gi];
         assign half_w[gi] = mult_q[gi][0];
         assign load_w[gi] = cfg_ok && (wr_pll == 1'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mult_q[gi] <= RST_CODE;
               band_q[gi] <= 2'b00;
               pwr_q[gi]  <= RST_PWR;
            end else if (load_w[gi]) begin
               mult_q[gi] <= wr_mult;
               band_q[gi] <= wr_range;
               pwr_q[gi]  <= wr_pwroff;
            end
         end

         clksel_lock_timer #(.CNT_W(CNT_W)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_w[gi]),
            .load_val (lock_cycles),
            .pll_off  (off_w[gi]),
            .lock_in  (pll_lock_in[gi]),
            .locked   (locked_w[gi])
         );

         assign cfg_mult[gi*MULT_W +: MULT_W] = mult_q[gi];
         assign cfg_range[gi*2 +: 2]          = band_q[gi];
         assign cfg_pwroff[gi]                = pwr_q[gi];

         // R4
         band_never_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            band_q[gi] != BAND_RSVD);
      end
   endgenerate

   clksel_rules u_rules (
      .valid      (wr_valid),
      .op         (op_w),
      .tgt_pll    (wr_pll),
      .band       (wr_range),
      .req_sel    (wr_sel),
      .cur_sel    (sel_q),
      .pll_off    (off_w),
      .pll_locked (locked_w),
      .pll_half   (half_w),
      .cfg_ok     (cfg_ok),
      .sel_ok     (sel_ok),
      .err_set    (err_set)
   );

   assign clr_eff = (wr_valid && op_w == OP_CLR) ? wr_clr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         err_q <= '0;
      end else begin
         if (sel_ok)
            sel_q <= wr_sel;
         err_q <= (err_q & ~clr_eff) | err_set;
      end
   end

   assign clk_sel    = sel_q;
   assign pll_locked = locked_w;
   assign err_flags  = err_q;

   // R6
   rise_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_q) |-> $past(locked_w[1]));

   // R6
   fall_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_q) |-> $past(locked_w[0]));

   // R7
   sel_not_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !off_w[sel_q]);

   // R3
   live_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(sel_q) |-> $stable(mult_q[sel_q]));

   // R11
   err_clear_only_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_q) & ~err_q & ~$past(clr_eff)) == '0);

endmodule

// File: tb/clksel_guard_tb_top.sv
`timescale 1ns/1ps
module clksel_guard_tb_top;

   localparam int MW  = 5;
   localparam int CW  = 8;
   localparam int RM0 = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [1:0]    wr_op = 2'd3;
   logic          wr_pll = 1'b0;
   logic [MW-1:0] wr_mult = '0;
   logic [1:0]    wr_range = 2'b00;
   logic          wr_pwroff = 1'b0;
   logic          wr_sel = 1'b0;
   logic [4:0]    wr_clr = '0;
   logic [CW-1:0] lock_cycles = 8'd3;
   logic [1:0]    pll_lock_in = 2'b11;
   logic          clk_sel;
   logic [1:0]    pll_locked;
   logic [2*MW-1:0] cfg_mult;
   logic [3:0]    cfg_range;
   logic [1:0]    cfg_pwroff;
   logic [4:0]    err_flags;

   always #2 clk = ~clk;

   clksel_guard #(.MULT_W(MW), .CNT_W(CW), .RESET_MULT0(RM0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_op(wr_op),
      .wr_pll(wr_pll), .wr_mult(wr_mult), .wr_range(wr_range),
      .wr_pwroff(wr_pwroff), .wr_sel(wr_sel), .wr_clr(wr_clr),
      .lock_cycles(lock_cycles), .pll_lock_in(pll_lock_in),
      .clk_sel(clk_sel), .pll_locked(pll_locked), .cfg_mult(cfg_mult),
      .cfg_range(cfg_range), .cfg_pwroff(cfg_pwroff), .err_flags(err_flags)
   );

   int checks = 0;
   int errors = 0;

   // reference state derived from the requirements
   int   m_mult [2];
   int   m_band [2];
   int   m_pwr  [2];
   int   m_cnt  [2];
   int   m_sel;
   int   m_err;

   function automatic bit m_off(int i);
      return (m_mult[i] == 0) || (m_pwr[i] != 0);
   endfunction

   function automatic bit m_lock(int i);
      return (m_cnt[i] == 0) && !m_off(i) && pll_lock_in[i];
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      int em [5];
      em[0] = 3; em[1] = 8; em[2] = 7; em[3] = 9; em[4] = 4;
      check(clk_sel == m_sel[0], "R6 clk_sel", clk_sel, m_sel);
      for (int i = 0; i < 2; i++) begin
         check(cfg_mult[i*MW +: MW] == MW'(m_mult[i]), "R2 mult",
               cfg_mult[i*MW +: MW], m_mult[i]);
         check(cfg_range[i*2 +: 2] == 2'(m_band[i]), "R2 band",
               cfg_range[i*2 +: 2], m_band[i]);
         check(cfg_pwroff[i] == m_pwr[i][0], "R2 pwroff", cfg_pwroff[i], m_pwr[i]);
         check(pll_locked[i] == m_lock(i), "R5 locked", pll_locked[i], m_lock(i));
      end
      for (int b = 0; b < 5; b++)
         check(err_flags[b] == m_err[b], $sformatf("R%0d err bit %0d", em[b], b),
               err_flags[b], m_err[b]);
   endtask

   // one operation, one clock edge; starts and ends at a falling edge
   task automatic step(int op, int p, int mult, int band, int pwr, int s, int clr);
      int ld [2];
      wr_valid  = 1'b1;
      wr_op     = 2'(op);
      wr_pll    = p[0];
      wr_mult   = MW'(mult);
      wr_range  = 2'(band);
      wr_pwroff = pwr[0];
      wr_sel    = s[0];
      wr_clr    = 5'(clr);
      ld[0] = 0; ld[1] = 0;
      if (op == 0) begin
         if (p == m_sel) m_err |= 1;
         else if (band == 3) m_err |= 16;
         else ld[p] = 1;
      end else if (op == 1 && s != m_sel) begin
         if (m_off(s)) m_err |= 4;
         else if (!m_lock(s)) m_err |= 2;
         else if ((m_mult[0] % 2 == 1) && (m_mult[1] % 2 == 1)) m_err |= 8;
         else m_sel = s;
      end else if (op == 2) begin
         m_err &= ~clr;
      end
      for (int i = 0; i < 2; i++) begin
         if (ld[i] != 0) begin
            m_mult[i] = mult; m_band[i] = band; m_pwr[i] = pwr;
            m_cnt[i] = int'(lock_cycles);
         end else if (m_cnt[i] > 0) begin
            m_cnt[i]--;
         end
      end
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      compare_all();
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(3, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rng;
      m_mult[0] = RM0; m_mult[1] = 0;
      m_band[0] = 0;   m_band[1] = 0;
      m_pwr[0]  = 0;   m_pwr[1]  = 1;
      m_cnt[0]  = 0;   m_cnt[1]  = 0;
      m_sel = 0; m_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(clk_sel == 1'b0, "R1 sel", clk_sel, 0);
      check(cfg_mult == {5'd0, 5'(RM0)}, "R1 mult", cfg_mult, RM0);
      check(cfg_pwroff == 2'b10, "R1 pwroff", cfg_pwroff, 2);
      check(pll_locked == 2'b01, "R1 locked", pll_locked, 1);
      check(err_flags == 5'd0, "R1 err", err_flags, 0);

      // R3: write aimed at the running PLL
      step(0, 0, 12, 1, 0, 0, 0);
      check(err_flags == 5'b00001 && cfg_mult[MW-1:0] == 5'(RM0), "R3 reject",
            err_flags, 1);
      // R11 partial clear leaves other bits, full clear empties
      step(2, 0, 0, 0, 0, 0, 5'b11110);
      check(err_flags == 5'b00001, "R11 partial clr", err_flags, 1);
      step(2, 0, 0, 0, 0, 0, 5'b00001);
      check(err_flags == 5'b00000, "R11 clr", err_flags, 0);
      // R7 select of an off PLL
      step(1, 0, 0, 0, 0, 1, 0);
      check(clk_sel == 1'b0 && err_flags[2], "R7 off select", clk_sel, 0);
      // R4 reserved band, wrong PLL takes priority over band
      step(0, 1, 12, 3, 0, 0, 0);
      check(cfg_mult[2*MW-1:MW] == 5'd0 && err_flags[4], "R4 rsvd band",
            cfg_mult[2*MW-1:MW], 0);
      step(2, 0, 0, 0, 0, 0, 31);
      step(0, 0, 12, 3, 0, 0, 0);
      check(err_flags == 5'b00001, "R3 priority over R4", err_flags, 1);
      step(2, 0, 0, 0, 0, 0, 31);
      // R2 accepted write, R8 early select, R5 lock timing
      lock_cycles = 8'd3;
      step(0, 1, 12, 1, 0, 0, 0);
      check(pll_locked[1] == 1'b0, "R5 unlocked after write", pll_locked[1], 0);
      step(1, 0, 0, 0, 0, 1, 0);
      check(clk_sel == 1'b0 && err_flags[1], "R8 early select", clk_sel, 0);
      idle(1);
      check(pll_locked[1] == 1'b0, "R5 not yet", pll_locked[1], 0);
      idle(1);
      check(pll_locked[1] == 1'b1, "R5 locked on time", pll_locked[1], 1);
      // R6 switch with no wait
      step(1, 0, 0, 0, 0, 1, 0);
      check(clk_sel == 1'b1, "R6 switch", clk_sel, 1);
      // R10 same-value select
      step(2, 0, 0, 0, 0, 0, 31);
      step(1, 0, 0, 0, 0, 1, 0);
      check(clk_sel == 1'b1 && err_flags == 5'd0, "R10 no-op select", err_flags, 0);
      // R9 half to half
      step(0, 0, 9, 0, 0, 0, 0);
      idle(3);
      step(1, 0, 0, 0, 0, 0, 0);
      check(clk_sel == 1'b0, "R9 half to full allowed", clk_sel, 0);
      step(0, 1, 13, 2, 0, 0, 0);
      idle(3);
      step(1, 0, 0, 0, 0, 1, 0);
      check(clk_sel == 1'b0 && err_flags[3], "R9 half swap refused", clk_sel, 0);
      // R5 lock input qualifier
      pll_lock_in = 2'b01;
      #1;
      check(pll_locked[1] == 1'b0, "R5 lock_in low", pll_locked[1], 0);
      pll_lock_in = 2'b11;
      // R11 reserved op
      step(3, 1, 5, 3, 1, 1, 31);
      check(err_flags[3] == 1'b1, "R11 nop keeps flags", err_flags[3], 1);
      step(2, 0, 0, 0, 0, 0, 31);

      // pseudo-random sweep against the model
      rng = 32'h1234_5678;
      lock_cycles = 8'd2;
      for (int n = 0; n < 4000; n++) begin
         int op, p, mu, bd, pw, sl, cl;
         int codes [6];
         codes[0] = 0; codes[1] = 8; codes[2] = 9; codes[3] = 12;
         codes[4] = 13; codes[5] = 6;
         rng = rng * 32'd1664525 + 32'd1013904223;
         op = int'(rng[31:30]);
         p  = int'(rng[29]);
         mu = rng[28] ? int'(rng[27:23]) : codes[int'(rng[22:20]) % 6];
         bd = int'(rng[19:18]);
         pw = (rng[17:15] == 3'd0) ? 1 : 0;
         sl = int'(rng[14]);
         cl = int'(rng[12:8]);
         if (rng[7:4] == 4'd0) pll_lock_in = 2'(rng[3:2]);
         else if (rng[7:4] == 4'd1) pll_lock_in = 2'b11;
         if (rng[1:0] == 2'd0) lock_cycles = 8'(rng[6:5]);
         step(op, p, mu, bd, pw, sl, cl);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule